// File: doc/BRIEF.md
# Four-State Hard-Decision Viterbi Decoder

This block recovers the information bits of a rate-1/2, constraint-length-3 convolutional code from hard-decided received symbols. Each clock cycle in which `in_valid` is high delivers one received 2-bit code pair. A branch metric stage measures the Hamming distance from that pair to each of the four possible code pairs. Two butterfly add-compare-select units then update four 6-bit path metrics. One survivor decision bit per state is stored for each trellis step in a circular history of 16 words.

Once 15 steps of history lie behind the current step, a traceback starts from the state with the smallest path metric and walks 15 decisions back. It releases the input bit of the oldest step in the window. After this fill phase, each step yields exactly one decoded bit, in order. To flush the final information bits, the user appends 15 extra coded steps, for example an encoded zero tail.

Top module: `vit_hd_decoder`

## Requirements
- R1: The code pair for input bit u, with b1 and b2 the two preceding inputs (b1 the newer), is in_sym[1] = u^b1^b2 and in_sym[0] = u^b2. Each branch metric is the Hamming distance (0 to 2) between the received pair and that branch's code pair.
- R2: Each of the four next states is fed by two predecessors. The decoder adds each predecessor's 6-bit metric to its branch metric, keeps the smaller sum, and organises these updates as two butterflies.
- R3: After reset, state 0 holds metric 0 and the other three states hold a bias of 16. After every step all metrics are reduced by their minimum, so one metric is 0 and none approaches the 6-bit limit.
- R4: The survivor history holds 16 words of 4 bits, one bit per state. Exactly one word is written per step, at a pointer that advances by one and wraps.
- R5: A stored decision bit is 1 when the survivor comes from the lower-numbered predecessor. An equal comparison keeps the higher-numbered predecessor and stores 0.
- R6: During the first 15 steps after reset no decoded bit is released. The first one belongs to the 16th step.
- R7: From the 16th step on, each step produces exactly one cycle of out_valid, two clock edges after the step's in_valid cycle. Idle cycles produce none.
- R8: Traceback starts from the state with the smallest metric (the lowest index on ties) and follows 15 decisions. The released bit is the input of the oldest step in the window, so the decoded bits come out in transmission order.
- R9: An error-free coded stream, started from the all-zero encoder state, decodes to exactly the original bits, for any data pattern and any spacing of valid cycles.
- R10: A stream with two isolated channel bit errors inside one traceback window decodes without error.
- R11: While and right after reset, out_valid and out_bit are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A received code pair is present this cycle |
| in_sym | input | 2 | Hard-decided code pair, bit 1 from the 111 generator, bit 0 from the 101 generator |
| out_valid | output | 1 | A decoded bit is present this cycle |
| out_bit | output | 1 | Decoded information bit |

## Verification
Two functions can fall in the same cycle. The traceback reads the survivor history and path metrics left by the previous step, while the add-compare-select stage writes a new history word and new metrics for the next step. Back-to-back valid cycles provoke this overlap, and streams with idle gaps between steps avoid it. The bench decodes the same kind of data both ways and judges each decoded bit against the bits it encoded itself. It also checks that out_valid appears exactly two edges after each steady-phase step and never on idle cycles.

// File: rtl/vit_pkg.sv
package vit_pkg;

  localparam int NST = 4;   // trellis states for constraint length 3

  typedef enum logic {PH_FILL = 1'b0, PH_STEADY = 1'b1} phase_e;

  // code pair emitted when input u leaves state s = {newer bit, older bit}
  function automatic logic [1:0] branch_code(input logic [1:0] s, input logic u);
    return {u ^ s[1] ^ s[0], u ^ s[0]};
  endfunction

endpackage

// File: rtl/vit_bmu.sv
module vit_bmu (
  input  logic [1:0]      sym,
  output logic [3:0][1:0] bm
);
  // bm[e] = Hamming distance between sym and code pair e
  for (genvar e = 0; e < 4; e++) begin : g_code
    logic [1:0] diff;
    assign diff  = sym ^ 2'(e);
    assign bm[e] = {diff[1] & diff[0], diff[1] ^ diff[0]};
  end

  always_comb begin
    for (int e = 0; e < 4; e++)
      assert (bm[e] != 2'd3);
  end
endmodule

// File: rtl/vit_acs_bfly.sv
module vit_acs_bfly #(
  parameter int MW = 6,
  parameter int BF = 0   // butterfly index: predecessors {BF,0} and {BF,1}
) (
  input  logic [MW-1:0]   pm_lo,
  input  logic [MW-1:0]   pm_hi,
  input  logic [3:0][1:0] bm,
  output logic [1:0][MW-1:0] nm,   // nm[u] feeds next state {u,BF}
  output logic [1:0]      dec
);
  import vit_pkg::*;
  localparam logic [1:0] ST_LO = 2'(2 * BF);
  localparam logic [1:0] ST_HI = 2'(2 * BF + 1);

  for (genvar u = 0; u < 2; u++) begin : g_out
    logic [1:0]    code_lo, code_hi;
    logic [MW-1:0] sum_lo, sum_hi;
    logic          take_lo;
    assign code_lo = branch_code(ST_LO, 1'(u));
    assign code_hi = branch_code(ST_HI, 1'(u));
    assign sum_lo  = pm_lo + MW'(bm[code_lo]);
    assign sum_hi  = pm_hi + MW'(bm[code_hi]);
    assign take_lo = (sum_lo < sum_hi);   // tie keeps the upper predecessor
    assign nm[u]   = take_lo ? sum_lo : sum_hi;
    assign dec[u]  = take_lo;
  end
endmodule

// File: rtl/vit_metric_reg.sv
module vit_metric_reg #(
  parameter int MW        = 6,
  parameter int INIT_BIAS = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               upd,
  input  logic [3:0][MW-1:0] nm,
  output logic [3:0][MW-1:0] pm,
  output logic [1:0]         best
);
  localparam logic [MW-1:0] BIAS   = MW'(INIT_BIAS);
  localparam logic [MW-1:0] SAFE_MAX = MW'((1 << MW) - 4);

  logic [MW-1:0] min_a, min_b, min_all;
  logic [3:0][MW-1:0] pm_q;

  assign min_a   = (nm[1] < nm[0]) ? nm[1] : nm[0];
  assign min_b   = (nm[3] < nm[2]) ? nm[3] : nm[2];
  assign min_all = (min_b < min_a) ? min_b : min_a;

  always_ff @(posedge clk) begin
    if (rst) begin
      pm_q[0] <= '0;
      pm_q[1] <= BIAS;
      pm_q[2] <= BIAS;
      pm_q[3] <= BIAS;
    end else if (upd) begin
      for (int i = 0; i < 4; i++) pm_q[i] <= nm[i] - min_all;
    end
  end

  // argmin of the stored metrics, lowest index wins ties
  always_comb begin
    logic [MW-1:0] bv;
    best = 2'd0;
    bv   = pm_q[0];
    for (int i = 1; i < 4; i++) begin
      if (pm_q[i] < bv) begin
        bv   = pm_q[i];
        best = 2'(i);
      end
    end
  end

  assign pm = pm_q;

  AST_MIN_ZERO: assert property (@(posedge clk) disable iff (rst)
    $past(upd) |-> (pm_q[0] == '0 || pm_q[1] == '0 || pm_q[2] == '0 || pm_q[3] == '0)); // R3

  for (genvar i = 0; i < 4; i++) begin : g_chk
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
      pm_q[i] < SAFE_MAX); // R3
  end
endmodule

// File: rtl/vit_path_mem.sv
module vit_path_mem #(
  parameter int DEPTH = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 we,
  input  logic [3:0]           wdata,
  output logic [DEPTH-1:0][3:0] words,
  output logic [$clog2(DEPTH)-1:0] last_ptr
);
  localparam int PW = $clog2(DEPTH);

  logic [PW-1:0]          wptr_q;
  logic [DEPTH-1:0][3:0]  mem_q;

  always_ff @(posedge clk) begin
    if (rst) wptr_q <= '0;
    else if (we) wptr_q <= wptr_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (we) mem_q[wptr_q] <= wdata;
  end

  assign words    = mem_q;
  assign last_ptr = wptr_q - 1'b1;

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (rst)
    we |=> (wptr_q == $past(wptr_q) + 1'b1)); // R4
  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(wptr_q)); // R4
endmodule

// File: rtl/vit_traceback.sv
module vit_traceback #(
  parameter int DEPTH  = 16,
  parameter int TB_LEN = 15
) (
  input  logic [DEPTH-1:0][3:0]       words,
  input  logic [$clog2(DEPTH)-1:0]    last_ptr,
  input  logic [1:0]                  start,
  output logic                        bit_out
);
  localparam int PW = $clog2(DEPTH);

  logic [TB_LEN:0][1:0] st;
  assign st[0] = start;

  // step back: predecessor is {s[0], 0} when the decision says lower, else {s[0], 1}
  for (genvar i = 0; i < TB_LEN; i++) begin : g_hop
    logic [PW-1:0] idx;
    logic          d;
    assign idx       = last_ptr - PW'(i);
    assign d         = words[idx][st[i]];
    assign st[i + 1] = {st[i][0], ~d};
  end

  assign bit_out = st[TB_LEN][1];

  initial assert (TB_LEN < DEPTH);
endmodule

// File: rtl/vit_ctrl.sv
module vit_ctrl #(
  parameter int TB_LEN = 15
) (
  input  logic clk,
  input  logic rst,
  input  logic step,
  output logic go,
  output logic emit,
  output logic steady
);
  import vit_pkg::*;
  localparam int CW = $clog2(TB_LEN) + 1;

  phase_e        phase_q;
  logic [CW-1:0] cnt_q;
  logic          go_q, emit_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_FILL;
      cnt_q   <= '0;
      go_q    <= 1'b0;
      emit_q  <= 1'b0;
    end else begin
      go_q   <= step && (phase_q == PH_STEADY);
      emit_q <= go_q;
      if (step && phase_q == PH_FILL) begin
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == CW'(TB_LEN - 1)) phase_q <= PH_STEADY;
      end
    end
  end

  assign go     = go_q;
  assign emit   = emit_q;
  assign steady = (phase_q == PH_STEADY);

  AST_EMIT_AFTER_STEP: assert property (@(posedge clk) disable iff (rst)
    emit_q |-> $past(step, 2)); // R7
  AST_FILL_SILENT: assert property (@(posedge clk) disable iff (rst)
    emit_q |-> $past(phase_q == PH_STEADY)); // R6
endmodule

// File: rtl/vit_hd_decoder.sv
module vit_hd_decoder #(
  parameter int MW        = 6,
  parameter int INIT_BIAS = 16,
  parameter int DEPTH     = 16,
  parameter int TB_LEN    = 15
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       in_valid,
  input  logic [1:0] in_sym,
  output logic       out_valid,
  output logic       out_bit
);
  localparam int PW = $clog2(DEPTH);

  logic [3:0][1:0]    bm;
  logic [3:0][MW-1:0] pm, nm;
  logic [3:0]         dec;
  logic [1:0]         best;
  logic [DEPTH-1:0][3:0] words;
  logic [PW-1:0]      last_ptr;
  logic               tb_bit, go, emit, steady;
  logic               out_bit_q;

  vit_bmu u_bmu (.sym(in_sym), .bm(bm));

  // butterfly b: predecessors 2b, 2b+1 -> next states b (u=0) and 2+b (u=1)
  for (genvar b = 0; b < 2; b++) begin : g_bfly
    logic [1:0][MW-1:0] bnm;
    logic [1:0]         bdec;
    vit_acs_bfly #(.MW(MW), .BF(b)) u_acs (
      .pm_lo(pm[2*b]), .pm_hi(pm[2*b+1]), .bm(bm),
      .nm(bnm), .dec(bdec)
    );
    assign nm[b]      = bnm[0];
    assign nm[2 + b]  = bnm[1];
    assign dec[b]     = bdec[0];
    assign dec[2 + b] = bdec[1];
  end

  vit_metric_reg #(.MW(MW), .INIT_BIAS(INIT_BIAS)) u_pm (
    .clk(clk), .rst(rst), .upd(in_valid), .nm(nm), .pm(pm), .best(best)
  );

  vit_path_mem #(.DEPTH(DEPTH)) u_hist (
    .clk(clk), .rst(rst), .we(in_valid), .wdata(dec),
    .words(words), .last_ptr(last_ptr)
  );

  vit_traceback #(.DEPTH(DEPTH), .TB_LEN(TB_LEN)) u_tb (
    .words(words), .last_ptr(last_ptr), .start(best), .bit_out(tb_bit)
  );

  vit_ctrl #(.TB_LEN(TB_LEN)) u_ctrl (
    .clk(clk), .rst(rst), .step(in_valid), .go(go), .emit(emit), .steady(steady)
  );

  always_ff @(posedge clk) begin
    if (rst) out_bit_q <= 1'b0;
    else if (go) out_bit_q <= tb_bit;
  end

  assign out_valid = emit;
  assign out_bit   = out_bit_q;

  AST_GO_NEEDS_STEADY: assert property (@(posedge clk) disable iff (rst)
    go |-> steady); // R6
  AST_RESET_QUIET: assert property (@(posedge clk)
    $past(rst) |-> (!out_valid && !out_bit)); // R11
endmodule

// File: tb/vit_hd_decoder_tb.sv
module vit_hd_decoder_tb_top;
  localparam int TB_LEN = 15;
  localparam int MAXN   = 1200;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [1:0] in_sym = 2'b00;
  logic out_valid, out_bit;

  int checks = 0;
  int errors = 0;

  logic info [MAXN];
  int   out_idx;
  int   steps;
  logic last_v;
  int   last_steps;
  logic mon_en = 1'b0;
  string cur_tag;

  always #5 clk = ~clk;

  vit_hd_decoder dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sym(in_sym),
    .out_valid(out_valid), .out_bit(out_bit)
  );

  // monitor: one sample per cycle, 1 ns after the rising edge
  always @(posedge clk) begin
    #1;
    if (!mon_en) begin
      out_idx = 0; steps = 0; last_v = 1'b0; last_steps = 0;
    end else begin
      logic exp_ov;
      exp_ov = last_v && (last_steps >= TB_LEN + 1);
      if (exp_ov || out_valid) begin
        checks++;
        if (out_valid !== exp_ov) begin
          errors++;
          $display("FAIL R6 R7 out_valid timing: got %0b expected %0b (steps %0d)",
                   out_valid, exp_ov, last_steps);
        end
      end
      if (out_valid === 1'b1) begin
        checks++;
        if (out_idx >= MAXN || out_bit !== info[out_idx]) begin
          errors++;
          $display("FAIL %s decoded bit %0d: got %0b expected %0b",
                   cur_tag, out_idx, out_bit, (out_idx < MAXN) ? info[out_idx] : 1'bx);
        end
        out_idx++;
      end
      if (in_valid) steps++;
      last_v     = in_valid;
      last_steps = steps;
    end
  end

  task automatic do_reset();
    mon_en = 1'b0;
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b0; in_sym = 2'b00;
    repeat (3) @(negedge clk);
    checks++;   // R11 reset state
    if (out_valid !== 1'b0 || out_bit !== 1'b0) begin
      errors++;
      $display("FAIL R11 reset outputs: got %0b/%0b expected 0/0", out_valid, out_bit);
    end
    rst = 1'b0;
    @(negedge clk);
    checks++;   // R11 right after reset
    if (out_valid !== 1'b0 || out_bit !== 1'b0) begin
      errors++;
      $display("FAIL R11 after reset: got %0b/%0b expected 0/0", out_valid, out_bit);
    end
    mon_en = 1'b1;
  endtask

  // pat: 0 zeros, 1 ones, 2 alternating, 3 pseudo-random; err_every flips one bit each k steps
  task automatic run_stream(input int n, input int pat, input int gap,
                            input int e1, input int e2, input int err_every,
                            input string tag);
    logic [15:0] lfsr;
    logic b1, b2, u;
    logic [1:0] c;
    do_reset();
    cur_tag = tag;
    lfsr = 16'hACE1 ^ 16'(n * 37 + pat);
    b1 = 1'b0; b2 = 1'b0;
    for (int k = 0; k < n + TB_LEN; k++) begin
      if (k >= n) u = 1'b0;
      else begin
        case (pat)
          0: u = 1'b0;
          1: u = 1'b1;
          2: u = 1'(k % 2);
          default: begin
            u = lfsr[0];
            lfsr = {lfsr[0] ^ lfsr[2] ^ lfsr[3] ^ lfsr[5], lfsr[15:1]};
          end
        endcase
        info[k] = u;
      end
      c = {u ^ b1 ^ b2, u ^ b2};
      b2 = b1; b1 = u;
      if (k == e1) c[1] = ~c[1];
      if (k == e2) c[0] = ~c[0];
      if (err_every > 0 && k < n && k % err_every == err_every / 2) c[k % 2] = ~c[k % 2];
      @(negedge clk);
      in_valid = 1'b1; in_sym = c;
      if (gap != 0) begin
        for (int g = 0; g < (k * 7 + gap) % 3; g++) begin
          @(negedge clk);
          in_valid = 1'b0;
        end
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
    repeat (5) @(negedge clk);
    checks++;
    if (out_idx != n) begin
      errors++;
      $display("FAIL R7 %s output count: got %0d expected %0d", tag, out_idx, n);
    end
  endtask

  initial begin
    run_stream(40,   0, 0, -1, -1, 0,  "R1 R9 zeros");
    run_stream(40,   1, 0, -1, -1, 0,  "R1 R2 R9 ones");
    run_stream(40,   2, 1, -1, -1, 0,  "R2 R9 alternating gapped");
    run_stream(150,  3, 0, -1, -1, 0,  "R8 R9 random back-to-back");
    run_stream(150,  3, 2, -1, -1, 0,  "R4 R8 R9 random gapped");
    run_stream(1,    3, 0, -1, -1, 0,  "R6 R8 single step window");
    run_stream(100,  3, 0, 30, 37, 0,  "R5 R10 two errors");
    run_stream(100,  2, 1, 60, 66, 0,  "R5 R10 two errors gapped");
    run_stream(60,   3, 0, 3,  12, 0,  "R3 R10 errors near start");
    run_stream(1000, 3, 0, -1, -1, 40, "R3 R10 long run isolated errors");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(10 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog expired: got hang expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule